// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block holds a set of programmable debug comparators: instruction-address slots (breakpoints) and data-address slots (watchpoints). Each slot has a 32-bit value register and a control register. On every cycle the block compares the presented fetch address against every breakpoint slot, and the presented data-access address against every watchpoint slot. It reports a registered per-slot hit vector and a one-cycle event pulse for each class.

A slot matches a window of up to four bytes (breakpoints) or eight bytes (watchpoints). The window starts at the word-aligned value register. A byte-select mask in the control register picks which bytes of that window are watched, so an unaligned halfword or byte is programmed as an aligned value with a shifted mask. Watchpoints are further filtered by access direction, and every slot is filtered by privilege level. The highest-numbered breakpoint slot can run in an inverted mode that fires on every fetch outside its window, which gives single-step.

A global monitor-enable bit in a status register gates all comparisons. A read-only ID register reports the slot counts and a debug version. Software reaches all registers through a simple valid/write/address/data port with one cycle of read latency.

Top module: `dbg_cmp_bank`

## Requirements
- R1: After reset, every value and control register reads 0, the monitor-enable bit reads 0, and no hit or event output is set.
- R2: Address 0x20 is read-only. It reads (NUM_WP-1) in bits 31:28, (NUM_BP-1) in bits 27:24, DBG_VER in bits 19:16 and 0 elsewhere, and writes to it change nothing.
- R3: A read request (regValid=1, regWrite=0) returns regRdata with regRvalid=1 exactly one cycle later. A write produces no regRvalid. The address map is as follows. When regAddr[5:4]=00, regAddr[7:6] selects the register kind (0 breakpoint value, 1 breakpoint control, 2 watchpoint value, 3 watchpoint control) and regAddr[3:0] selects the slot. Address 0x21 is the status register, with bit 0 as monitor enable. A slot index at or above the slot count reads 0.
- R4: The control register layout is: bit 0 enable, bit 1 privileged-level enable, bit 2 user-level enable, bit 3 load, bit 4 store, bits 12:5 byte-select mask (bit 5 = byte 0), bit 13 mismatch. A watchpoint control keeps bits 12:0. A breakpoint control keeps bits 0-2 and 8:5, plus bit 13 only on the mismatch slot. All other bits read 0.
- R5: A breakpoint slot matches a fetch when fetchAddr[31:2] equals value[31:2] and the mask bit selected by fetchAddr[1:0] is set.
- R6: A watchpoint slot matches when d = dataAddr - (value with bits 1:0 cleared) lies in 0..7 and mask bit d is set. This covers 1-, 2-, 4- and 8-byte windows.
- R7: A watchpoint fires on a store (dataStore=1) only if its store bit is set, and on a load only if its load bit is set.
- R8: A slot fires only if the bit for the current level is set: privMode=1 uses the privileged bit, privMode=0 uses the user bit.
- R9: When NUM_BP>1, the slot NUM_BP-1 with mismatch set fires on every valid fetch that does not match its window. The mismatch bit of any other slot cannot be set.
- R10: No slot fires while monitor enable is 0 or while its own enable bit is 0.
- R11: bpHit and wpHit are registered and reflect the addresses presented one cycle earlier. Only fetches with fetchValid=1 and data accesses with dataValid=1 can fire. bpEvent and wpEvent are the OR of the respective hit vectors, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the request |
| regRvalid | output | 1 | Read data valid |
| fetchAddr | input | 32 | Instruction fetch address |
| fetchValid | input | 1 | Fetch address is valid |
| dataAddr | input | 32 | Data access address |
| dataValid | input | 1 | Data access is valid |
| dataStore | input | 1 | 1 = store, 0 = load |
| privMode | input | 1 | 1 = privileged level, 0 = user level |
| bpHit | output | NUM_BP | Registered per-slot breakpoint hits |
| wpHit | output | NUM_WP | Registered per-slot watchpoint hits |
| bpEvent | output | 1 | Any breakpoint hit |
| wpEvent | output | 1 | Any watchpoint hit |

## Verification
Hit vectors and event pulses are due one clock after the addresses are presented. Register read data is due one clock after the read request. A register write takes effect for comparisons from the next clock on. The bench drives every stimulus on a falling edge and samples on the following falling edge, so exactly one rising edge separates cause and effect in every check. The vector table changes the addresses on each falling edge, so each row's result is compared only against that row's inputs.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  localparam int DATA_W = 32;
  localparam int SLOT_W = 4;

  localparam int CTL_EN     = 0;
  localparam int CTL_PRIV   = 1;
  localparam int CTL_USER   = 2;
  localparam int CTL_LOAD   = 3;
  localparam int CTL_STORE  = 4;
  localparam int CTL_BAS    = 5;
  localparam int CTL_MISM   = 13;

  localparam logic [DATA_W-1:0] BP_CTL_MASK = 32'h0000_01E7;
  localparam logic [DATA_W-1:0] WP_CTL_MASK = 32'h0000_1FFF;
  localparam logic [DATA_W-1:0] MISM_MASK   = 32'h0000_2000;

  typedef enum logic [1:0] {
    KIND_BPVAL = 2'd0,
    KIND_BPCTL = 2'd1,
    KIND_WPVAL = 2'd2,
    KIND_WPCTL = 2'd3
  } slotKind_e;

  typedef struct packed {
    logic              slotWr;
    slotKind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] wdata;
  } strobe_t;

  function automatic logic levelOk(input logic [DATA_W-1:0] ctl, input logic priv);
    return priv ? ctl[CTL_PRIV] : ctl[CTL_USER];
  endfunction
endpackage

// File: rtl/dbg_cmp_ctrl.sv
module dbg_cmp_ctrl
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 4,
  parameter int DBG_VER = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] slotRdata,
  output strobe_t           strobe,
  output logic              monitorEn,
  output logic [DATA_W-1:0] regRdata,
  output logic              regRvalid
);
  localparam logic [3:0] WP_FIELD  = 4'(NUM_WP - 1);
  localparam logic [3:0] BP_FIELD  = 4'(NUM_BP - 1);
  localparam logic [3:0] VER_FIELD = 4'(DBG_VER);
  localparam logic [DATA_W-1:0] ID_WORD = {WP_FIELD, BP_FIELD, 4'h0, VER_FIELD, 16'h0000};

  logic isSys;
  logic isSlot;
  logic statusWr;
  logic [DATA_W-1:0] rdNext;

  assign isSys    = regAddr[5];
  assign isSlot   = !regAddr[5] && !regAddr[4];
  assign statusWr = regValid && regWrite && isSys && regAddr[0];

  always_comb begin
    strobe.slotWr = regValid && regWrite && isSlot;
    strobe.kind   = slotKind_e'(regAddr[7:6]);
    strobe.slot   = regAddr[3:0];
    strobe.wdata  = regWdata;
  end

  always_comb begin
    if (isSys) rdNext = regAddr[0] ? {{(DATA_W-1){1'b0}}, monitorEn} : ID_WORD;
    else if (isSlot) rdNext = slotRdata;
    else rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monitorEn <= 1'b0;
      regRdata  <= '0;
      regRvalid <= 1'b0;
    end else begin
      if (statusWr) monitorEn <= regWdata[0];
      regRvalid <= regValid && !regWrite;
      if (regValid && !regWrite) regRdata <= rdNext;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    regValid && !regWrite |=> regRvalid); // R3
  AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> !regRvalid); // R3
  AST_MONITOR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && regWrite && regAddr == 8'h21) |=> $stable(monitorEn)); // R10
endmodule

// File: rtl/dbg_cmp_match.sv
module dbg_cmp_match
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              monitorEn,
  input  logic [DATA_W-1:0] fetchAddr,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] dataAddr,
  input  logic              dataValid,
  input  logic              dataStore,
  input  logic              privMode,
  output logic [DATA_W-1:0] slotRdata,
  output logic [NUM_BP-1:0] bpHit,
  output logic [NUM_WP-1:0] wpHit,
  output logic              bpEvent,
  output logic              wpEvent
);
  logic [DATA_W-1:0] bpValArr [NUM_BP];
  logic [DATA_W-1:0] bpCtlArr [NUM_BP];
  logic [DATA_W-1:0] wpValArr [NUM_WP];
  logic [DATA_W-1:0] wpCtlArr [NUM_WP];
  logic [NUM_BP-1:0] bpNext;
  logic [NUM_WP-1:0] wpNext;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    localparam bit HAS_MISM = (NUM_BP > 1) && (i == NUM_BP - 1);
    localparam logic [DATA_W-1:0] KEEP = HAS_MISM ? (BP_CTL_MASK | MISM_MASK) : BP_CTL_MASK;
    logic [DATA_W-1:0] valQ, ctlQ, diff;
    logic [3:0] bas;
    logic inWin, mism;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ <= '0;
        ctlQ <= '0;
      end else if (strobe.slotWr && strobe.slot == SLOT_W'(i)) begin
        if (strobe.kind == KIND_BPVAL) valQ <= strobe.wdata;
        if (strobe.kind == KIND_BPCTL) ctlQ <= strobe.wdata & KEEP;
      end
    end

    assign diff  = fetchAddr - {valQ[DATA_W-1:2], 2'b00};
    assign bas   = ctlQ[CTL_BAS +: 4];
    assign inWin = (diff[DATA_W-1:2] == '0) && bas[diff[1:0]];
    assign mism  = HAS_MISM ? ctlQ[CTL_MISM] : 1'b0;
    assign bpNext[i] = monitorEn && fetchValid && ctlQ[CTL_EN] &&
                       levelOk(ctlQ, privMode) && (mism ? !inWin : inWin);
    assign bpValArr[i] = valQ;
    assign bpCtlArr[i] = ctlQ;

    AST_BP_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !ctlQ[CTL_EN] |=> !bpHit[i]); // R10
    AST_BP_LEVEL_FILTER: assert property (@(posedge clk) disable iff (!rstN)
      !privMode && !ctlQ[CTL_USER] |=> !bpHit[i]); // R8
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    logic [DATA_W-1:0] valQ, ctlQ, diff;
    logic [7:0] bas;
    logic inWin, dirOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ <= '0;
        ctlQ <= '0;
      end else if (strobe.slotWr && strobe.slot == SLOT_W'(j)) begin
        if (strobe.kind == KIND_WPVAL) valQ <= strobe.wdata;
        if (strobe.kind == KIND_WPCTL) ctlQ <= strobe.wdata & WP_CTL_MASK;
      end
    end

    assign diff  = dataAddr - {valQ[DATA_W-1:2], 2'b00};
    assign bas   = ctlQ[CTL_BAS +: 8];
    assign inWin = (diff[DATA_W-1:3] == '0) && bas[diff[2:0]];
    assign dirOk = dataStore ? ctlQ[CTL_STORE] : ctlQ[CTL_LOAD];
    assign wpNext[j] = monitorEn && dataValid && ctlQ[CTL_EN] &&
                       levelOk(ctlQ, privMode) && dirOk && inWin;
    assign wpValArr[j] = valQ;
    assign wpCtlArr[j] = ctlQ;

    AST_WP_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
      dataValid && dataStore && !ctlQ[CTL_STORE] |=> !wpHit[j]); // R7
    AST_WP_LOAD_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
      dataValid && !dataStore && !ctlQ[CTL_LOAD] |=> !wpHit[j]); // R7
    AST_WP_LEVEL_FILTER: assert property (@(posedge clk) disable iff (!rstN)
      privMode && !ctlQ[CTL_PRIV] |=> !wpHit[j]); // R8
  end

  always_comb begin
    slotRdata = '0;
    case (strobe.kind)
      KIND_BPVAL: for (int k = 0; k < NUM_BP; k++) if (strobe.slot == SLOT_W'(k)) slotRdata = bpValArr[k];
      KIND_BPCTL: for (int k = 0; k < NUM_BP; k++) if (strobe.slot == SLOT_W'(k)) slotRdata = bpCtlArr[k];
      KIND_WPVAL: for (int k = 0; k < NUM_WP; k++) if (strobe.slot == SLOT_W'(k)) slotRdata = wpValArr[k];
      default:    for (int k = 0; k < NUM_WP; k++) if (strobe.slot == SLOT_W'(k)) slotRdata = wpCtlArr[k];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpHit   <= '0;
      wpHit   <= '0;
      bpEvent <= 1'b0;
      wpEvent <= 1'b0;
    end else begin
      bpHit   <= bpNext;
      wpHit   <= wpNext;
      bpEvent <= |bpNext;
      wpEvent <= |wpNext;
    end
  end

  AST_MONITOR_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !monitorEn |=> (bpHit == '0) && (wpHit == '0)); // R10
  AST_NO_FETCH_NO_BP: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !bpEvent); // R11
  AST_NO_DATA_NO_WP: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> !wpEvent); // R11
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int NUM_BP  = 4,
  parameter int NUM_WP  = 4,
  parameter int DBG_VER = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regRvalid,
  input  logic [31:0]       fetchAddr,
  input  logic              fetchValid,
  input  logic [31:0]       dataAddr,
  input  logic              dataValid,
  input  logic              dataStore,
  input  logic              privMode,
  output logic [NUM_BP-1:0] bpHit,
  output logic [NUM_WP-1:0] wpHit,
  output logic              bpEvent,
  output logic              wpEvent
);
  strobe_t           strobe;
  logic              monitorEn;
  logic [DATA_W-1:0] slotRdata;

  dbg_cmp_ctrl #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .DBG_VER(DBG_VER)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .slotRdata(slotRdata),
    .strobe(strobe), .monitorEn(monitorEn), .regRdata(regRdata), .regRvalid(regRvalid)
  );

  dbg_cmp_match #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_match (
    .clk(clk), .rstN(rstN), .strobe(strobe), .monitorEn(monitorEn),
    .fetchAddr(fetchAddr), .fetchValid(fetchValid), .dataAddr(dataAddr),
    .dataValid(dataValid), .dataStore(dataStore), .privMode(privMode),
    .slotRdata(slotRdata), .bpHit(bpHit), .wpHit(wpHit),
    .bpEvent(bpEvent), .wpEvent(wpEvent)
  );
endmodule

// File: tb/dbg_cmp_bank_bench.sv
module dbg_cmp_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regValid = 1'b0, regWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic regRvalid;
  logic [31:0] fetchAddr = '0, dataAddr = '0;
  logic fetchValid = 1'b0, dataValid = 1'b0, dataStore = 1'b0, privMode = 1'b0;
  logic [3:0] bpHit, wpHit;
  logic bpEvent, wpEvent;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmp_bank u_dbg_cmp_bank (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regRvalid(regRvalid),
    .fetchAddr(fetchAddr), .fetchValid(fetchValid), .dataAddr(dataAddr),
    .dataValid(dataValid), .dataStore(dataStore), .privMode(privMode),
    .bpHit(bpHit), .wpHit(wpHit), .bpEvent(bpEvent), .wpEvent(wpEvent)
  );

  typedef struct packed {
    logic [31:0] fa;
    logic        fv;
    logic [31:0] da;
    logic        dv;
    logic        st;
    logic        pv;
    logic [3:0]  expBp;
    logic [3:0]  expWp;
  } vec_t;

  // Slot setup used by the table:
  // BP0 0x1000 all 4 bytes, both levels; BP1 0x2000 bytes 2-3, user only; BP2 disabled
  // WP0 0x4000 8 bytes load+store; WP1 0x5000 byte 3 load only; WP2 0x6004 bytes 0-1 store, priv only
  localparam int NVEC = 16;
  localparam vec_t TBL [NVEC] = '{
    '{32'h1000, 1'b1, 32'h0,    1'b0, 1'b0, 1'b1, 4'b0001, 4'b0000}, // R5 R10
    '{32'h1003, 1'b1, 32'h0,    1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000}, // R5
    '{32'h1004, 1'b1, 32'h0,    1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000}, // R5
    '{32'h2002, 1'b1, 32'h0,    1'b0, 1'b0, 1'b0, 4'b0010, 4'b0000}, // R5 R8
    '{32'h2002, 1'b1, 32'h0,    1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000}, // R8
    '{32'h2001, 1'b1, 32'h0,    1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000}, // R5
    '{32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000}, // R11
    '{32'h0,    1'b0, 32'h4007, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0001}, // R6
    '{32'h0,    1'b0, 32'h4008, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0000}, // R6
    '{32'h0,    1'b0, 32'h5003, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0010}, // R6 R7
    '{32'h0,    1'b0, 32'h5003, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000}, // R7
    '{32'h0,    1'b0, 32'h6005, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b0100}, // R7 R8
    '{32'h0,    1'b0, 32'h6005, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000}, // R8
    '{32'h0,    1'b0, 32'h6004, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0000}, // R7
    '{32'h1000, 1'b1, 32'h4000, 1'b1, 1'b0, 1'b1, 4'b0001, 4'b0001}, // R11
    '{32'h0,    1'b0, 32'h4000, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b0000}  // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    d = regRdata; v = regRvalid;
    regValid = 1'b0;
  endtask

  task automatic present(input vec_t t);
    @(negedge clk);
    fetchAddr = t.fa; fetchValid = t.fv; dataAddr = t.da;
    dataValid = t.dv; dataStore = t.st; privMode = t.pv;
  endtask

  function automatic logic [31:0] outWord();
    return {22'd0, bpEvent, wpEvent, bpHit, wpHit};
  endfunction

  function automatic logic [31:0] expWord(input logic [3:0] b, input logic [3:0] w);
    return {22'd0, |b, |w, b, w};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R11: actual 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic rv;
    vec_t idle;
    idle = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 hits after reset", outWord(), 32'h0);
    regRd(8'h40, rd, rv); chk("R1 bp ctl reset", rd, 32'h0);
    regRd(8'h83, rd, rv); chk("R1 wp value reset", rd, 32'h0);
    regRd(8'h21, rd, rv); chk("R1 status reset", rd, 32'h0);
    chk("R3 rvalid one cycle after read", {31'd0, rv}, 32'h1);

    regRd(8'h20, rd, rv); chk("R2 id word", rd, 32'h3305_0000);
    regWr(8'h20, 32'hFFFF_FFFF);
    regRd(8'h20, rd, rv); chk("R2 id write ignored", rd, 32'h3305_0000);

    regWr(8'h21, 32'h1);
    @(negedge clk);
    chk("R3 no rvalid after write", {31'd0, regRvalid}, 32'h0);
    regRd(8'h21, rd, rv); chk("R3 status readback", rd, 32'h1);

    regWr(8'h00, 32'h1000); regWr(8'h40, 32'h1E7);
    regWr(8'h01, 32'h2000); regWr(8'h41, 32'h185);
    regWr(8'h02, 32'h1000); regWr(8'h42, 32'h1E6);
    regWr(8'h80, 32'h4000); regWr(8'hC0, 32'h1FFF);
    regWr(8'h81, 32'h5000); regWr(8'hC1, 32'h10F);
    regWr(8'h82, 32'h6004); regWr(8'hC2, 32'h73);
    regRd(8'hC0, rd, rv); chk("R4 wp ctl readback", rd, 32'h1FFF);
    regRd(8'h81, rd, rv); chk("R3 wp value readback", rd, 32'h5000);
    regRd(8'hC5, rd, rv); chk("R3 unimplemented slot reads 0", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      present(TBL[i]);
      @(negedge clk);
      chk($sformatf("R11 table row %0d", i), outWord(), expWord(TBL[i].expBp, TBL[i].expWp));
    end
    present(idle);

    regWr(8'h03, 32'h3000); regWr(8'h43, 32'h21E7);
    regRd(8'h43, rd, rv); chk("R9 mismatch bit kept on last slot", rd, 32'h21E7);
    present('{32'h3000, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, 4'b0, 4'b0});
    @(negedge clk); chk("R9 mismatch quiet inside window", outWord(), expWord(4'b0000, 4'b0));
    present('{32'h1000, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, 4'b0, 4'b0});
    @(negedge clk); chk("R9 mismatch fires outside window", outWord(), expWord(4'b1001, 4'b0));
    present('{32'h3004, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, 4'b0, 4'b0});
    @(negedge clk); chk("R9 mismatch next word", outWord(), expWord(4'b1000, 4'b0));
    present(idle);
    @(negedge clk); chk("R11 mismatch needs fetchValid", outWord(), 32'h0);
    regWr(8'h43, 32'h0);

    regWr(8'h41, 32'h2185);
    regRd(8'h41, rd, rv); chk("R9 mismatch bit dropped on other slot", rd, 32'h185);
    regWr(8'h42, 32'hFFFF_FFFF);
    regRd(8'h42, rd, rv); chk("R4 bp ctl writable bits", rd, 32'h1E7);

    regWr(8'h21, 32'h0);
    present('{32'h1000, 1'b1, 32'h4000, 1'b1, 1'b0, 1'b1, 4'b0, 4'b0});
    @(negedge clk); chk("R10 monitor off gates all", outWord(), 32'h0);
    regWr(8'h21, 32'h1);
    @(negedge clk); chk("R10 monitor on again", outWord(), expWord(4'b0101, 4'b0001));
    present(idle);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule